// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Spatial Dither

This block sits at the end of a display pipeline and cuts each colour channel of a 12-bit RGB pixel down to 6 or 8 bits. It can do this in three ways. The plain way drops the low bits. Truncation can also round half-up, saturating at the top of the range. Spatial dithering adds pseudo-random noise from 28-bit linear feedback shift registers before the cut, which trades banding for fine grain.

The noise generators are either shared, so one generator feeds all three channels, or separate, with a distinct feedback tap for each colour. Each generator takes a programmable seed. A seed is loaded while reset is held and, optionally, again at the first pixel of every frame. An optional high-pass mode uses the difference between the current and the previous generator state as the noise. The reduced pixel leaves one clock after it enters, together with its valid and start-of-frame flags.

Top module: `pix_depth_reducer`

## Requirements
- R1: `out_valid` and `out_sof` equal `in_valid` and `in_sof` of the previous clock. While `rst` is high, all outputs are zero.
- R2: `cfg_depth`=0 gives a 6-bit result in bits [5:0] of each output channel, with bits [7:6] zero. `cfg_depth`=1 gives an 8-bit result in bits [7:0]. The number of dropped bits D is therefore 6 or 4.
- R3: With `cfg_dither_en`=0 and `cfg_trunc_en`=0, each output channel is the input channel shifted right by D.
- R4: With `cfg_dither_en`=0 and `cfg_trunc_en`=1, `cfg_trunc_round`=0 drops the low D bits. `cfg_trunc_round`=1 gives (pix + 2^(D-1)) >> D, saturated at 2^(12-D)-1.
- R5: With `cfg_dither_en`=1, which takes priority over truncation, each channel is min((pix + n) >> D, 2^(12-D)-1). Here n is bits [D-1:0] of the noise source.
- R6: Generator c has tap t (R:3, G:9, B:13). On each advance its state s becomes {s[26:0], s[27]^s[t-1]}, which is the polynomial x^28+x^t+1. A generator advances exactly once per clock with `in_valid`=1 and holds otherwise.
- R7: With `cfg_rgb_rand`=0, all three channels take their noise from the red generator (tap 3). With `cfg_rgb_rand`=1, each channel uses its own generator.
- R8: While `rst` is high, each generator loads its channel's seed. A seed of zero is loaded as 1.
- R9: With `cfg_frame_rand`=1, a pixel with `in_valid`=1 and `in_sof`=1 uses the freshly loaded seed as the generator state, and the generator then advances from that state. With `cfg_frame_rand`=0, `in_sof` has no effect on the noise.
- R10: With `cfg_hp_en`=1, the noise source is (s - p) mod 2^12 on bits [11:0]. Here p is the state before the last advance, and p equals s right after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| cfg_dither_en | input | 1 | Spatial dither enable |
| cfg_trunc_en | input | 1 | Truncation enable |
| cfg_trunc_round | input | 1 | 0 drop, 1 round half-up |
| cfg_depth | input | 1 | 0 six bits, 1 eight bits |
| cfg_hp_en | input | 1 | High-pass noise |
| cfg_frame_rand | input | 1 | Reseed at every frame start |
| cfg_rgb_rand | input | 1 | Separate generator per colour |
| cfg_seed_r | input | 28 | Red seed |
| cfg_seed_g | input | 28 | Green seed |
| cfg_seed_b | input | 28 | Blue seed |
| out_valid | output | 1 | Output valid |
| out_sof | output | 1 | Output start of frame |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
Several properties are checked on every clock. The one-cycle delay of valid and frame start is checked, and so is the zeroed upper field at 6-bit depth. The plain bit drop is checked against the input. Rounding of an all-ones input is checked to pin at the maximum. A dithered result is checked to stay between the truncated value and one above it. The exact noise values can only be shown by the bench's scenarios, which run a model of the generators. Those scenarios cover the per-colour taps, shared use of the red generator, seed loading and zero-seed repair, reseeding at frame start, stalls on invalid cycles, and the high-pass difference.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    localparam int PIX_IN_W    = 12;
    localparam int NARROW_W    = 6;
    localparam int WIDE_W      = 8;
    localparam int LFSR_W      = 28;
    localparam int NCH         = 3;
    localparam int DROP_NARROW = PIX_IN_W - NARROW_W;
    localparam int DROP_WIDE   = PIX_IN_W - WIDE_W;

    typedef logic [LFSR_W-1:0]   lfsr_t;
    typedef logic [PIX_IN_W-1:0] pix_t;
    typedef logic [WIDE_W-1:0]   res_t;

    typedef enum logic {
        DEPTH_NARROW = 1'b0,
        DEPTH_WIDE   = 1'b1
    } depth_e;

    typedef struct packed {
        logic   dither_en;
        logic   trunc_en;
        logic   trunc_round;
        logic   hp_en;
        depth_e depth;
    } red_cfg_t;

    function automatic int tap_of(input int ch);
        case (ch)
            0:       return 3;
            1:       return 9;
            default: return 13;
        endcase
    endfunction

    function automatic lfsr_t lfsr_step(input lfsr_t s, input int tap);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[tap-1]};
    endfunction

    function automatic lfsr_t seed_fix(input lfsr_t s);
        return (s == '0) ? lfsr_t'(1) : s;
    endfunction
endpackage

// File: rtl/bdr_noise_gen.sv
module bdr_noise_gen
    import bdr_pkg::*;
#(
    parameter int TAP = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  reload,
    input  lfsr_t seed,
    output lfsr_t cur,
    output lfsr_t prev
);
    lfsr_t state_q;
    lfsr_t prev_q;
    lfsr_t seed_ok;

    assign seed_ok = seed_fix(seed);
    assign cur     = reload ? seed_ok : state_q;
    assign prev    = reload ? seed_ok : prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= seed_ok;
            prev_q  <= seed_ok;
        end else if (advance) begin
            prev_q  <= cur;
            state_q <= lfsr_step(cur, TAP);
        end
    end
endmodule

// File: rtl/bdr_reduce.sv
module bdr_reduce
    import bdr_pkg::*;
(
    input  pix_t     pix,
    input  lfsr_t    nz_cur,
    input  lfsr_t    nz_prev,
    input  red_cfg_t cfg,
    output res_t     res
);
    localparam pix_t MASK_WIDE   = pix_t'((1 << DROP_WIDE) - 1);
    localparam pix_t MASK_NARROW = pix_t'((1 << DROP_NARROW) - 1);
    localparam pix_t HALF_WIDE   = pix_t'(1 << (DROP_WIDE - 1));
    localparam pix_t HALF_NARROW = pix_t'(1 << (DROP_NARROW - 1));

    pix_t                noise_raw;
    pix_t                add;
    logic [PIX_IN_W:0]   sum;
    logic [WIDE_W:0]     q_wide;
    logic [NARROW_W:0]   q_narrow;
    logic                wide;

    always_comb begin
        wide      = (cfg.depth == DEPTH_WIDE);
        noise_raw = cfg.hp_en ? (nz_cur[PIX_IN_W-1:0] - nz_prev[PIX_IN_W-1:0])
                              : nz_cur[PIX_IN_W-1:0];
        if (cfg.dither_en)
            add = noise_raw & (wide ? MASK_WIDE : MASK_NARROW);
        else if (cfg.trunc_en && cfg.trunc_round)
            add = wide ? HALF_WIDE : HALF_NARROW;
        else
            add = '0;
        sum      = {1'b0, pix} + {1'b0, add};
        q_wide   = sum[PIX_IN_W -: WIDE_W+1];
        q_narrow = sum[PIX_IN_W -: NARROW_W+1];
        if (wide)
            res = q_wide[WIDE_W] ? {WIDE_W{1'b1}} : q_wide[WIDE_W-1:0];
        else
            res = q_narrow[NARROW_W] ? res_t'({NARROW_W{1'b1}})
                                     : res_t'(q_narrow[NARROW_W-1:0]);
    end
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer
    import bdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [11:0] in_r,
    input  logic [11:0] in_g,
    input  logic [11:0] in_b,
    input  logic        cfg_dither_en,
    input  logic        cfg_trunc_en,
    input  logic        cfg_trunc_round,
    input  logic        cfg_depth,
    input  logic        cfg_hp_en,
    input  logic        cfg_frame_rand,
    input  logic        cfg_rgb_rand,
    input  logic [27:0] cfg_seed_r,
    input  logic [27:0] cfg_seed_g,
    input  logic [27:0] cfg_seed_b,
    output logic        out_valid,
    output logic        out_sof,
    output logic [7:0]  out_r,
    output logic [7:0]  out_g,
    output logic [7:0]  out_b
);
    red_cfg_t cfg;
    pix_t     pix_a  [NCH];
    lfsr_t    seed_a [NCH];
    lfsr_t    gcur   [NCH];
    lfsr_t    gprev  [NCH];
    res_t     res_a  [NCH];
    logic     reload;

    assign cfg.dither_en   = cfg_dither_en;
    assign cfg.trunc_en    = cfg_trunc_en;
    assign cfg.trunc_round = cfg_trunc_round;
    assign cfg.hp_en       = cfg_hp_en;
    assign cfg.depth       = depth_e'(cfg_depth);

    assign pix_a[0]  = in_r;
    assign pix_a[1]  = in_g;
    assign pix_a[2]  = in_b;
    assign seed_a[0] = cfg_seed_r;
    assign seed_a[1] = cfg_seed_g;
    assign seed_a[2] = cfg_seed_b;

    assign reload = in_valid && in_sof && cfg_frame_rand;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lfsr_t sel_cur;
        lfsr_t sel_prev;

        bdr_noise_gen #(.TAP(tap_of(c))) u_gen (
            .clk     (clk),
            .rst     (rst),
            .advance (in_valid),
            .reload  (reload),
            .seed    (seed_a[c]),
            .cur     (gcur[c]),
            .prev    (gprev[c])
        );

        assign sel_cur  = cfg_rgb_rand ? gcur[c]  : gcur[0];
        assign sel_prev = cfg_rgb_rand ? gprev[c] : gprev[0];

        bdr_reduce u_red (
            .pix     (pix_a[c]),
            .nz_cur  (sel_cur),
            .nz_prev (sel_prev),
            .cfg     (cfg),
            .res     (res_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_r     <= '0;
            out_g     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_sof;
            out_r     <= res_a[0];
            out_g     <= res_a[1];
            out_b     <= res_a[2];
        end
    end
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sof,
    input logic [11:0] in_r,
    input logic [11:0] in_g,
    input logic [11:0] in_b,
    input logic        cfg_dither_en,
    input logic        cfg_trunc_en,
    input logic        cfg_trunc_round,
    input logic        cfg_depth,
    input logic        out_valid,
    input logic        out_sof,
    input logic [7:0]  out_r,
    input logic [7:0]  out_g,
    input logic [7:0]  out_b
);
    logic       past_ok;
    logic [7:0] flr_r;
    logic [7:0] top_val;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign flr_r   = cfg_depth ? in_r[11:4] : {2'b00, in_r[11:6]};
    assign top_val = cfg_depth ? 8'hFF : 8'h3F;

    a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (out_valid == $past(in_valid)));

    a_r1_sof_delay: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_valid) |-> (out_sof == $past(in_sof)));

    a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_valid && !$past(cfg_depth))
            |-> (out_r[7:6] == 2'b00 && out_g[7:6] == 2'b00 && out_b[7:6] == 2'b00));

    a_r3_plain_drop: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_valid && $past(!cfg_dither_en && !cfg_trunc_en))
            |-> (out_r == $past(flr_r)));

    a_r4_round_saturates: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_valid
         && $past(!cfg_dither_en && cfg_trunc_en && cfg_trunc_round && in_r == 12'hFFF))
            |-> (out_r == $past(top_val)));

    a_r5_dither_bounds: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_valid && $past(cfg_dither_en))
            |-> (out_r >= $past(flr_r) && {1'b0, out_r} <= {1'b0, $past(flr_r)} + 9'd1));
endmodule

bind pix_depth_reducer bdr_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_sof          (in_sof),
    .in_r            (in_r),
    .in_g            (in_g),
    .in_b            (in_b),
    .cfg_dither_en   (cfg_dither_en),
    .cfg_trunc_en    (cfg_trunc_en),
    .cfg_trunc_round (cfg_trunc_round),
    .cfg_depth       (cfg_depth),
    .out_valid       (out_valid),
    .out_sof         (out_sof),
    .out_r           (out_r),
    .out_g           (out_g),
    .out_b           (out_b)
);

// File: tb/sim_pix_depth_reducer.sv
`timescale 1ns/1ps
module sim_pix_depth_reducer;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof;
    logic [11:0] in_r, in_g, in_b;
    logic        cfg_dither_en, cfg_trunc_en, cfg_trunc_round, cfg_depth;
    logic        cfg_hp_en, cfg_frame_rand, cfg_rgb_rand;
    logic [27:0] cfg_seed_r, cfg_seed_g, cfg_seed_b;
    logic        out_valid, out_sof;
    logic [7:0]  out_r, out_g, out_b;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [27:0] m_cur  [3];
    logic [27:0] m_prev [3];
    logic        e_valid, e_sof;
    logic [7:0]  e_pix  [3];

    always #10 clk = ~clk;

    pix_depth_reducer u0 (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [27:0] m_step(input logic [27:0] s, input int t);
        logic fb;
        fb = s[27] ^ s[t-1];
        return {s[26:0], fb};
    endfunction

    function automatic logic [27:0] m_fix(input logic [27:0] s);
        if (s == 28'd0) return 28'd1;
        return s;
    endfunction

    function automatic int m_tap(input int c);
        if (c == 0) return 3;
        if (c == 1) return 9;
        return 13;
    endfunction

    // Expected reduction following R2..R5 and R10
    function automatic logic [7:0] m_reduce(input int pix, input logic [27:0] s,
                                            input logic [27:0] p);
        int d, top, add, q, nsrc;
        d    = cfg_depth ? 4 : 6;
        top  = (1 << (12 - d)) - 1;
        nsrc = cfg_hp_en ? ((int'(s[11:0]) - int'(p[11:0])) & 12'hFFF) : int'(s[11:0]);
        if (cfg_dither_en)                      add = nsrc % (1 << d);
        else if (cfg_trunc_en && cfg_trunc_round) add = 1 << (d - 1);
        else                                    add = 0;
        q = (pix + add) >> d;
        if (q > top) q = top;
        return 8'(q);
    endfunction

    task automatic model_reset();
        m_cur[0] = m_fix(cfg_seed_r); m_cur[1] = m_fix(cfg_seed_g); m_cur[2] = m_fix(cfg_seed_b);
        for (int c = 0; c < 3; c++) m_prev[c] = m_cur[c];
    endtask

    task automatic check(input string req);
        n_tests++;
        if (out_valid !== e_valid || (e_valid && (out_sof !== e_sof || out_r !== e_pix[0]
            || out_g !== e_pix[1] || out_b !== e_pix[2]))) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b s=%0b %h %h %h expected v=%0b s=%0b %h %h %h",
                     req, out_valid, out_sof, out_r, out_g, out_b,
                     e_valid, e_sof, e_pix[0], e_pix[1], e_pix[2]);
        end
    endtask

    // drive one pixel at the falling edge, check at the next falling edge
    task automatic pixel(input logic v, input logic sof, input int r, input int g,
                         input int b, input string req);
        logic [27:0] ec [3];
        logic [27:0] ep [3];
        logic [27:0] sd [3];
        int pv [3];
        int src;
        in_valid = v; in_sof = sof;
        in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
        pv[0] = r; pv[1] = g; pv[2] = b;
        sd[0] = cfg_seed_r; sd[1] = cfg_seed_g; sd[2] = cfg_seed_b;
        for (int c = 0; c < 3; c++) begin
            if (v && sof && cfg_frame_rand) begin
                ec[c] = m_fix(sd[c]); ep[c] = ec[c];
            end else begin
                ec[c] = m_cur[c]; ep[c] = m_prev[c];
            end
        end
        for (int c = 0; c < 3; c++) begin
            src = cfg_rgb_rand ? c : 0;
            e_pix[c] = m_reduce(pv[c], ec[src], ep[src]);
        end
        e_valid = v; e_sof = sof;
        if (v) begin
            for (int c = 0; c < 3; c++) begin
                m_prev[c] = ec[c];
                m_cur[c]  = m_step(ec[c], m_tap(c));
            end
        end
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
        repeat (2) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_r !== 8'd0 || out_g !== 8'd0 || out_b !== 8'd0) begin
            n_fail++;
            $display("FAIL R1: reset outputs actual v=%0b %h %h %h expected 0 0 0 0",
                     out_valid, out_r, out_g, out_b);
        end
        model_reset();
        rst = 1'b0;
    endtask

    task automatic set_cfg(input logic dith, input logic tr, input logic rnd, input logic dep,
                           input logic hp, input logic fr, input logic rgb);
        cfg_dither_en = dith; cfg_trunc_en = tr; cfg_trunc_round = rnd; cfg_depth = dep;
        cfg_hp_en = hp; cfg_frame_rand = fr; cfg_rgb_rand = rgb;
    endtask

    task automatic burst(input int n, input string req, input bit gaps, input int sof_every);
        logic v;
        for (int i = 0; i < n; i++) begin
            v = gaps ? ($urandom % 4 != 0) : 1'b1;
            pixel(v, (sof_every > 0) && (i % sof_every == 0), $urandom % 4096,
                  $urandom % 4096, $urandom % 4096, req);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        cfg_seed_r = 28'h0A5C3F1; cfg_seed_g = 28'h7123456; cfg_seed_b = 28'h0ABCDEF;
        set_cfg(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        do_reset();

        // R3 plain drop, both depths (R2)
        set_cfg(0, 0, 0, 0, 0, 0, 0); burst(20, "R3 narrow R2", 1, 0);
        set_cfg(0, 0, 0, 1, 0, 0, 0); burst(20, "R3 wide R2", 1, 0);

        // R4 truncation modes, with corner cases
        set_cfg(0, 1, 0, 0, 0, 0, 0); burst(15, "R4 drop", 0, 0);
        set_cfg(0, 1, 1, 0, 0, 0, 0); burst(15, "R4 round narrow", 0, 0);
        pixel(1, 0, 12'hFFF, 12'h020, 12'h01F, "R4 round saturate narrow");
        set_cfg(0, 1, 1, 1, 0, 0, 0);
        pixel(1, 0, 12'hFFF, 12'h008, 12'h007, "R4 round saturate wide");
        burst(15, "R4 round wide", 0, 0);

        // R5 and R6 dither, separate generators, stalls on invalid cycles
        set_cfg(1, 1, 1, 1, 0, 0, 1); burst(40, "R5 R6 dither per-colour", 1, 0);
        set_cfg(1, 0, 0, 0, 0, 0, 1); burst(40, "R5 R6 dither narrow", 1, 0);
        pixel(1, 0, 12'hFFF, 12'hFFF, 12'hFFF, "R5 dither saturate");

        // R7 shared generator
        set_cfg(1, 0, 0, 1, 0, 0, 0); burst(40, "R7 shared noise", 1, 0);

        // R9 frame reseed on, then off (sof ignored)
        set_cfg(1, 0, 0, 1, 0, 1, 1); burst(48, "R9 frame reseed", 1, 8);
        set_cfg(1, 0, 0, 1, 0, 0, 1); burst(32, "R9 sof ignored", 0, 8);

        // R10 high-pass noise, including right after reseed
        set_cfg(1, 0, 0, 1, 1, 1, 1); burst(40, "R10 high-pass", 1, 10);
        set_cfg(1, 0, 0, 0, 1, 0, 0); burst(30, "R10 high-pass shared", 0, 0);

        // R8 zero seed loaded as 1
        cfg_seed_r = 28'd0; cfg_seed_g = 28'd0; cfg_seed_b = 28'h0000003;
        do_reset();
        set_cfg(1, 0, 0, 1, 0, 0, 1); burst(30, "R8 zero seed", 0, 0);

        // R1 mixed random traffic across all modes
        for (int k = 0; k < 200; k++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                    $urandom % 2, $urandom % 2, $urandom % 2);
            burst(5, "R1 R6 mixed", 1, 3);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule